// File: doc/BRIEF.md
# Serial Memory Command Front End

This block terminates a four-wire serial peripheral bus (mode 0, MSB first) on behalf of a small byte-wide memory of 1K entries. It shifts in an 8-bit opcode, decodes it, and then runs one of six sequences. Two set and clear a write-enable latch. One writes the protection/watchdog status byte and one reads it. The last two write and read the array, which is a simple synchronous RAM standing in for the nonvolatile cells. The bus lines are brought into the system clock domain through a synchronizer, and bus edges are detected there. The bus clock may therefore stop at any point and resume later.

Writes to the array or to the status byte are staged while chip select is low. They take effect only at the rising edge of chip select, and only when the latch is set, no write cycle is running, and the target address lies outside the region chosen by the 3-bit protection code. An accepted write starts a busy window of a fixed number of system clocks, which is visible in the status byte. Reads are never blocked.

Top module: `spi_ee_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, the latch is clear, and MISO is low.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. A write issued after 06h then 04h has no effect on the array.
- R3: Array writes (opcode 02h) and status writes (opcode 01h) take effect only if the latch is set. The latch clears when an accepted write cycle starts, so a second write without a new 06h is ignored.
- R4: Status reads (opcode 05h) return bit 7 = write in progress, bits 6:5 = 0, bits 4:3 = watchdog select and bits 2:0 = protection code. A status write stores bits 4:0 of its data byte, and bits 7:5 of that byte are discarded.
- R5: Protection code 1 to 4 guards the first to fourth quarter of the array, code 5 the lower half, code 6 the lowest 16-byte page and code 7 the highest 16-byte page. Code 0 guards nothing. A write to a guarded address changes nothing, and the latch stays set.
- R6: Reads return stored data regardless of the protection code.
- R7: Bit 7 of the status byte stays high for BUSY_CLKS clocks after an accepted write. Array and status writes are ignored during that window, while status reads still work.
- R8: Opcode 03h is followed by a 16-bit address of which only the low 10 bits are used. Further bytes continue at the next address, and the address wraps from 3FFh to 000h.
- R9: If chip select rises before the whole data byte of a write has arrived, nothing is written and the latch keeps its value.
- R10: MOSI is sampled on rising SCK and MISO changes on falling SCK, MSB first. SCK may pause mid-byte without corrupting the transfer.
- R11: MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Bus clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
If the latch or the staged write flags are wrong, the error shows up at the ports only on a later read of the affected address. That read comes one full command (four bytes) after the offending chip-select edge. A wrong protection decode has the same delay. A wrong busy counter shows up directly in bit 7 of the next status read: it clears too early, sticks high, or lets a write slip into the busy window. A wrong bit counter or shift register corrupts the very first byte returned on MISO.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
   typedef enum logic [2:0] {
      PH_CMD, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_WSR, PH_RSR, PH_SKIP
   } phase_t;

   localparam logic [7:0] OP_SETWEL = 8'h06;
   localparam logic [7:0] OP_CLRWEL = 8'h04;
   localparam logic [7:0] OP_WRSR   = 8'h01;
   localparam logic [7:0] OP_RDSR   = 8'h05;
   localparam logic [7:0] OP_WRITE  = 8'h02;
   localparam logic [7:0] OP_READ   = 8'h03;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_ee_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[0] <= RST_VAL;
         else        stg[0] <= d_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= {STAGES{RST_VAL}};
         else        stg <= {stg[STAGES-2:0], d_in};
      end
   end

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_ee_lock.sv
module spi_ee_lock #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4,
   localparam int PG_W  = ADDR_W - PAGE_W
) (
   input  logic [2:0]      code,
   input  logic [PG_W-1:0] page,
   output logic            hit
);
   logic [1:0] quarter;
   assign quarter = page[PG_W-1 -: 2];

   always_comb begin
      unique case (code)
         3'd1:    hit = (quarter == 2'd0);
         3'd2:    hit = (quarter == 2'd1);
         3'd3:    hit = (quarter == 2'd2);
         3'd4:    hit = (quarter == 2'd3);
         3'd5:    hit = ~page[PG_W-1];
         3'd6:    hit = (page == '0);
         3'd7:    hit = (page == '1);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/spi_ee_ram.sv
module spi_ee_ram #(
   parameter int DW = 8,
   parameter int AW = 10,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 4,
   parameter int BUSY_CLKS   = 200,
   parameter int SYNC_STAGES = 2,
   localparam int BCW        = $clog2(BUSY_CLKS + 1),
   localparam int PG_W       = ADDR_W - PAGE_W
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   if (ADDR_W < PAGE_W + 2 || ADDR_W > 16) begin : g_bad_aw
      $error("spi_ee_ctrl: ADDR_W out of range");
   end
   if (BUSY_CLKS < 1) begin : g_bad_busy
      $error("spi_ee_ctrl: BUSY_CLKS must be positive");
   end

   // bus synchronisation and edge detection
   logic [2:0] sync_q;
   logic       sck_s, cs_s, si_s, sck_d, cs_d;
   logic       sck_rise, sck_fall, cs_rise;

   spi_ee_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_in({spi_mosi, spi_cs_n, spi_sck}), .q_out(sync_q)
   );
   assign sck_s    = sync_q[0];
   assign cs_s     = sync_q[1];
   assign si_s     = sync_q[2];
   assign sck_rise = sck_s & ~sck_d & ~cs_s;
   assign sck_fall = ~sck_s & sck_d & ~cs_s;
   assign cs_rise  = cs_s & ~cs_d;

   // command state
   phase_t            ph;
   logic              rd_mode;
   logic [2:0]        bitcnt, obit;
   logic [6:0]        shreg;
   logic [7:0]        byte_in, addr_hi, wdat_q, oreg, src_byte, stat_byte, ram_rdata;
   logic [4:0]        sr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              pend_wr, pend_sr, wel_q, miso_q;
   logic [1:0]        wd_q;
   logic [2:0]        bl_q;
   logic [BCW-1:0]    busy_cnt;
   logic              busy, lock_hit, commit_ok, ram_we, sr_we;

   assign byte_in   = {shreg, si_s};
   assign busy      = (busy_cnt != '0);
   assign stat_byte = {busy, 2'b00, wd_q, bl_q};
   assign src_byte  = (ph == PH_RSR) ? stat_byte : ram_rdata;
   assign commit_ok = cs_rise & wel_q & ~busy;
   assign ram_we    = commit_ok & pend_wr & ~lock_hit;
   assign sr_we     = commit_ok & pend_sr;

   spi_ee_lock #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_lock (
      .code(bl_q), .page(addr_q[ADDR_W-1:PAGE_W]), .hit(lock_hit)
   );

   spi_ee_ram #(.DW(8), .AW(ADDR_W)) u_ram (
      .clk(clk), .we(ram_we), .waddr(addr_q), .wdata(wdat_q),
      .raddr(addr_q), .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         cs_d     <= 1'b1;
         ph       <= PH_CMD;
         rd_mode  <= 1'b0;
         bitcnt   <= '0;
         obit     <= '0;
         shreg    <= '0;
         addr_hi  <= '0;
         addr_q   <= '0;
         wdat_q   <= '0;
         sr_q     <= '0;
         oreg     <= '0;
         pend_wr  <= 1'b0;
         pend_sr  <= 1'b0;
         wel_q    <= 1'b0;
         miso_q   <= 1'b0;
         wd_q     <= '0;
         bl_q     <= '0;
         busy_cnt <= '0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
         if (cs_s) begin
            ph     <= PH_CMD;
            bitcnt <= '0;
            obit   <= '0;
            miso_q <= 1'b0;
            if (cs_rise) begin
               pend_wr <= 1'b0;
               pend_sr <= 1'b0;
            end
         end else begin
            if (sck_rise) begin
               shreg  <= byte_in[6:0];
               bitcnt <= bitcnt + 3'd1;
               if (bitcnt == 3'd7) begin
                  unique case (ph)
                     PH_CMD: begin
                        unique case (byte_in)
                           OP_SETWEL: begin wel_q <= 1'b1; ph <= PH_SKIP; end
                           OP_CLRWEL: begin wel_q <= 1'b0; ph <= PH_SKIP; end
                           OP_WRSR:   ph <= PH_WSR;
                           OP_RDSR:   ph <= PH_RSR;
                           OP_WRITE:  begin rd_mode <= 1'b0; ph <= PH_AHI; end
                           OP_READ:   begin rd_mode <= 1'b1; ph <= PH_AHI; end
                           default:   ph <= PH_SKIP;
                        endcase
                     end
                     PH_AHI: begin
                        addr_hi <= byte_in;
                        ph      <= PH_ALO;
                     end
                     PH_ALO: begin
                        addr_q <= ADDR_W'({addr_hi, byte_in});
                        ph     <= rd_mode ? PH_RDAT : PH_WDAT;
                     end
                     PH_WDAT: if (!pend_wr) begin
                        wdat_q  <= byte_in;
                        pend_wr <= 1'b1;
                     end
                     PH_WSR: if (!pend_sr) begin
                        sr_q    <= byte_in[4:0];
                        pend_sr <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            if (sck_fall && (ph == PH_RDAT || ph == PH_RSR)) begin
               obit <= obit + 3'd1;
               if (obit == 3'd0) begin
                  miso_q <= src_byte[7];
                  oreg   <= {src_byte[6:0], 1'b0};
                  if (ph == PH_RDAT) addr_q <= addr_q + ADDR_W'(1);
               end else begin
                  miso_q <= oreg[7];
                  oreg   <= {oreg[6:0], 1'b0};
               end
            end
         end
         if (ram_we || sr_we) begin
            wel_q    <= 1'b0;
            busy_cnt <= BCW'(BUSY_CLKS);
         end else if (busy) begin
            busy_cnt <= busy_cnt - BCW'(1);
         end
         if (sr_we) begin
            wd_q <= sr_q[4:3];
            bl_q <= sr_q[2:0];
         end
      end
   end

   assign spi_miso = miso_q;
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ram_we,
   input logic       sr_we,
   input logic       wel,
   input logic       busy,
   input logic [2:0] bl,
   input logic       sck_rise,
   input logic       cs_s,
   input logic       miso
);
   AST_WRITE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || sr_we) |=> (!wel && busy)); // R3
   AST_NO_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ram_we); // R7
   AST_LOCK_HELD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(bl)); // R7
   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso); // R11
   AST_MISO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sck_rise |=> $stable(miso)); // R10
endmodule

bind spi_ee_ctrl spi_ee_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .sr_we(sr_we), .wel(wel_q),
   .busy(busy), .bl(bl_q), .sck_rise(sck_rise), .cs_s(cs_s), .miso(spi_miso)
);

// File: tb/sim_spi_ee_ctrl.sv
module sim_spi_ee_ctrl;
   localparam int CLK_P = 10;
   localparam int HALF  = 8;
   localparam int BUSY  = 1500;
   localparam int NVEC  = 6;
   localparam logic [17:0] VEC [NVEC] = '{
      {10'h000, 8'h3C}, {10'h1FF, 8'hA7}, {10'h200, 8'h01},
      {10'h3FF, 8'hFE}, {10'h155, 8'h55}, {10'h2AA, 8'hAA}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   spi_ee_ctrl #(.BUSY_CLKS(BUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits, input int pause);
      rx = '0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         spi_mosi = tx[i];
         wait_clk(HALF);
         if (i == 3) wait_clk(pause);
         rx[i] = spi_miso;
         spi_sck = 1'b1;
         wait_clk(HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic cs_lo();
      spi_cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_hi();
      wait_clk(HALF);
      spi_cs_n = 1'b1;
      wait_clk(2*HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      cs_lo(); xfer(op, d, 8, 0); cs_hi();
   endtask

   task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
      logic [7:0] d;
      cs_lo();
      xfer(8'h02, d, 8, 0); xfer(a[15:8], d, 8, 0); xfer(a[7:0], d, 8, 0); xfer(v, d, 8, 0);
      cs_hi();
   endtask

   task automatic rd_two(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1);
      logic [7:0] d;
      cs_lo();
      xfer(8'h03, d, 8, 0); xfer(a[15:8], d, 8, 0); xfer(a[7:0], d, 8, 0);
      xfer(8'h00, r0, 8, 0); xfer(8'h00, r1, 8, 0);
      cs_hi();
   endtask

   task automatic rd_byte(input logic [15:0] a, output logic [7:0] r);
      logic [7:0] d;
      rd_two(a, r, d);
   endtask

   task automatic rd_sr(output logic [7:0] r, input int pause);
      logic [7:0] d;
      cs_lo(); xfer(8'h05, d, 8, 0); xfer(8'h00, r, 8, pause); cs_hi();
   endtask

   task automatic wr_sr(input logic [7:0] v);
      logic [7:0] d;
      cs_lo(); xfer(8'h01, d, 8, 0); xfer(v, d, 8, 0); cs_hi();
   endtask

   task automatic settle();
      wait_clk(BUSY + 100);
   endtask

   initial begin
      wait_clk(190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, r2;
      wait_clk(4);
      chk("R1 miso in reset", {7'b0, spi_miso}, 8'h00);
      rst_n = 1'b1;
      wait_clk(4);
      rd_sr(r, 0);
      chk("R1 status after reset", r, 8'h00);
      chk("R11 miso idle", {7'b0, spi_miso}, 8'h00);

      // vector table: enabled write then readback, no protection
      for (int k = 0; k < NVEC; k++) begin
         cmd1(8'h06);
         wr_byte({6'b0, VEC[k][17:8]}, VEC[k][7:0]);
         settle();
         rd_byte({6'b0, VEC[k][17:8]}, r);
         chk("R3 table write/read", r, VEC[k][7:0]);
      end

      // latch cleared by completed write
      wr_byte(16'h0000, 8'h99);
      settle();
      rd_byte(16'h0000, r);
      chk("R3 no latch after write", r, 8'h3C);

      // set then clear latch
      cmd1(8'h06); cmd1(8'h04);
      wr_byte(16'h01FF, 8'h00);
      settle();
      rd_byte(16'h01FF, r);
      chk("R2 cleared latch", r, 8'hA7);

      // busy window
      cmd1(8'h06);
      wr_byte(16'h0155, 8'h66);
      rd_sr(r, 0);
      chk("R7 busy flag", r, 8'h80);
      cmd1(8'h06);
      wr_byte(16'h02AA, 8'h11);
      settle();
      rd_sr(r, 0);
      chk("R7 busy ends", r, 8'h00);
      rd_byte(16'h0155, r);
      chk("R7 accepted write", r, 8'h66);
      rd_byte(16'h02AA, r);
      chk("R7 write in busy ignored", r, 8'hAA);
      cmd1(8'h04);

      // protection code 1, watchdog select 2
      cmd1(8'h06); wr_sr(8'h11); settle();
      rd_sr(r, 0);
      chk("R4 status layout", r, 8'h11);
      cmd1(8'h06);
      wr_byte(16'h0000, 8'hEE);
      settle();
      rd_byte(16'h0000, r);
      chk("R5 code1 blocks q1", r, 8'h3C);
      chk("R6 locked read", r, 8'h3C);
      wr_byte(16'h01FF, 8'hEE);
      settle();
      rd_byte(16'h01FF, r);
      chk("R5 code1 allows q2, latch kept", r, 8'hEE);

      // protection code 7, spare bits discarded
      cmd1(8'h06); wr_sr(8'hFF); settle();
      rd_sr(r, 0);
      chk("R4 spare bits zero", r, 8'h1F);
      cmd1(8'h06);
      wr_byte(16'h03FF, 8'h00);
      settle();
      rd_byte(16'h03FF, r);
      chk("R5 code7 blocks top page", r, 8'hFE);
      wr_byte(16'h0200, 8'h99);
      settle();
      rd_byte(16'h0200, r);
      chk("R5 code7 allows 200h", r, 8'h99);

      // protection code 6
      cmd1(8'h06); wr_sr(8'h06); settle();
      cmd1(8'h06);
      wr_byte(16'h0000, 8'h42);
      settle();
      rd_byte(16'h0000, r);
      chk("R5 code6 blocks low page", r, 8'h3C);
      cmd1(8'h04);
      cmd1(8'h06); wr_sr(8'h00); settle();

      // wrapping sequential read, upper address bits dropped
      rd_two(16'h03FF, r, r2);
      chk("R8 read at 3FFh", r, 8'hFE);
      chk("R8 wrap to 000h", r2, 8'h3C);
      rd_byte(16'hFE00, r);
      chk("R8 upper address bits ignored", r, 8'h99);

      // aborted data byte
      cmd1(8'h06);
      cs_lo();
      xfer(8'h02, r, 8, 0); xfer(8'h01, r, 8, 0); xfer(8'h55, r, 8, 0);
      xfer(8'hC3, r, 4, 0);
      cs_hi();
      settle();
      rd_byte(16'h0155, r);
      chk("R9 partial byte dropped", r, 8'h66);
      wr_byte(16'h0155, 8'h77);
      settle();
      rd_byte(16'h0155, r);
      chk("R9 latch kept after abort", r, 8'h77);

      // paused clock mid-byte
      rd_sr(r, 400);
      chk("R10 paused transfer", r, 8'h00);
      chk("R11 miso idle end", {7'b0, spi_miso}, 8'h00);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule